// File: doc/BRIEF.md
# Register-Window Trap Entry Sequencer

This block carries out the entry half of trap handling on a processor with a rotating register-window file. Trap selection happens elsewhere. Once a trap has been chosen and the machine is not in error mode, the surrounding core pulses `start_i` and presents its current status and program-counter state.

The sequencer captures that state on the start edge and then steps through four working cycles, one per step:
- It moves the current window pointer down by one, wrapping modulo the window count, and writes the first status update: enable-traps cleared and the old supervisor bit copied into the previous-supervisor bit.
- It writes the first saved return address into local register 17 of the new window, through write port A.
- It writes the second saved return address into local register 18, through write port B.
- It enters supervisor mode and loads the new PC and nPC, from the trap base or from the fixed reset vector.

A one-cycle done pulse closes the sequence.

The saved pair depends on the annul flag. With annul clear, the saved addresses are PC and nPC. With annul set, they are nPC and nPC+4, and annul is cleared. A pending reset trap sends the core to address 0 with nPC 4 instead of the trap base, and clears the reset-trap flag.

Top module: `trap_entry_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `busy_o`, `done_o` and every write or clear strobe are 0.
- R2: A `start_i` pulse seen while idle gives exactly one cycle each of status write (`psr_we_o` high with `pc_we_o` low), port A write, port B write, redirect (`pc_we_o` and `psr_we_o`), and `done_o`, in that order. The status write comes in the cycle after the start edge. `busy_o` is high from the status write through `done_o`.
- R3: The new window pointer `cwp_o` equals the captured pointer minus one modulo NWINDOWS, so pointer 0 becomes NWINDOWS-1. Both register writes target this window.
- R4: In the status write, `et_o` is 0, `ps_o` equals the captured S bit, and `s_o` still equals the captured S bit.
- R5: With annul clear, port A writes the captured PC to register index 17 and port B writes the captured nPC to register index 18.
- R6: With annul set, port A writes nPC to index 17, port B writes nPC+4 to index 18, and `annul_clr_o` pulses together with the port B write. With annul clear, `annul_clr_o` stays 0.
- R7: With reset-trap clear, the redirect cycle gives `pc_o` = TBR and `npc_o` = TBR+4, and writes `s_o` = 1 with `et_o` = 0 and `ps_o` = captured S.
- R8: With reset-trap set, the redirect gives `pc_o` = 0 and `npc_o` = 4, and `rtrap_clr_o` pulses in that same cycle. With reset-trap clear, `rtrap_clr_o` stays 0.
- R9: A `start_i` pulse while busy is ignored: it starts no new sequence, and the running sequence keeps the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin trap entry (taken only when idle) |
| cwp_i | input | CWP_W | Current window pointer |
| s_i | input | 1 | Current supervisor bit |
| pc_i | input | AW | Current PC |
| npc_i | input | AW | Current nPC |
| tbr_i | input | AW | Trap base / vector address |
| annul_i | input | 1 | Delay-slot annul flag |
| rtrap_i | input | 1 | Reset trap pending |
| busy_o | output | 1 | Sequence in progress |
| psr_we_o | output | 1 | Status field write strobe |
| cwp_o | output | CWP_W | New window pointer |
| s_o | output | 1 | New supervisor bit |
| ps_o | output | 1 | New previous-supervisor bit |
| et_o | output | 1 | New enable-traps bit |
| rfa_we_o | output | 1 | Port A write enable |
| rfa_idx_o | output | 5 | Port A register index |
| rfa_win_o | output | CWP_W | Port A window |
| rfa_data_o | output | AW | Port A data |
| rfb_we_o | output | 1 | Port B write enable |
| rfb_idx_o | output | 5 | Port B register index |
| rfb_win_o | output | CWP_W | Port B window |
| rfb_data_o | output | AW | Port B data |
| pc_we_o | output | 1 | PC/nPC load strobe |
| pc_o | output | AW | New PC |
| npc_o | output | AW | New nPC |
| annul_clr_o | output | 1 | Clear the annul flag |
| rtrap_clr_o | output | 1 | Clear the reset-trap flag |
| done_o | output | 1 | Sequence finished |

## Verification
The bench drives traps with window pointer 0, a middle value and NWINDOWS-1. A design that decremented without wrapping would write the return addresses into window 31 instead of window 7. Both annul settings are crossed with both reset-trap settings:
- A swapped selection would save PC where nPC+4 belongs.
- A swapped vector choice would jump to the trap base on a reset.
- A missing clear pulse would leave the flag set for the next trap.

A second start during a running sequence, carrying different values, checks that a design which re-captured its inputs or restarted would produce extra or corrupted writes. The scoreboard reports these as unexpected items.

// File: rtl/trap_entry_pkg.sv
// Package: shared types and constants for the trap entry sequencer.
// Assumes register indices fit in 5 bits.
package trap_entry_pkg;

    // Local register indices that receive the two saved return addresses.
    localparam logic [4:0] SAVE_IDX_A = 5'd17;
    localparam logic [4:0] SAVE_IDX_B = 5'd18;

    // Sequencer steps, one cycle each.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PSR    = 3'd1,
        ST_SAVE_A = 3'd2,
        ST_SAVE_B = 3'd3,
        ST_REDIR  = 3'd4,
        ST_DONE   = 3'd5
    } trap_step_e;

endpackage

// File: rtl/twe_cwp_rot.sv
// Module: computes (cwp - 1) mod NWIN for the window rotation on trap entry.
// Assumes the incoming pointer is already below NWIN.
module twe_cwp_rot #(
    parameter int NWIN  = 8,
    parameter int CWP_W = 5
) (
    input  logic [CWP_W-1:0] cwp_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(NWIN - 1);

    // Decrement with wrap from window 0 to the top window.
    always_comb begin
        if (cwp_i == '0) cwp_o = TOP_WIN;
        else             cwp_o = cwp_i - CWP_W'(1);
    end
endmodule

// File: rtl/twe_ret_sel.sv
// Module: picks the pair of return addresses saved into the new window.
// Assumes addresses advance by 4 bytes per instruction.
module twe_ret_sel #(
    parameter int AW = 32
) (
    input  logic          annul_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] npc_i,
    output logic [AW-1:0] save_a_o,
    output logic [AW-1:0] save_b_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    // Annulled delay slot: resume after the slot instead of at it.
    always_comb begin
        if (annul_i) begin
            save_a_o = npc_i;
            save_b_o = npc_i + STEP;
        end else begin
            save_a_o = pc_i;
            save_b_o = npc_i;
        end
    end
endmodule

// File: rtl/twe_vector_sel.sv
// Module: chooses the redirect target pair: trap base or fixed reset vector.
// Assumes the reset vector is address 0.
module twe_vector_sel #(
    parameter int AW = 32
) (
    input  logic          rtrap_i,
    input  logic [AW-1:0] tbr_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] npc_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    // Reset trap ignores the trap base.
    always_comb begin
        if (rtrap_i) begin
            pc_o  = '0;
            npc_o = STEP;
        end else begin
            pc_o  = tbr_i;
            npc_o = tbr_i + STEP;
        end
    end
endmodule

// File: rtl/twe_fsm.sv
// Module: step sequencer. Walks IDLE -> PSR -> SAVE_A -> SAVE_B -> REDIR -> DONE
// one cycle per step, and decodes the strobes of each step.
// Assumes start is ignored outside IDLE.
module twe_fsm
    import trap_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic capture_o,
    output logic busy_o,
    output logic psr_step_o,
    output logic save_a_o,
    output logic save_b_o,
    output logic redir_o,
    output logic done_o
);
    trap_step_e state_q, state_d;

    // Next-step selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_PSR;
            ST_PSR:    state_d = ST_SAVE_A;
            ST_SAVE_A: state_d = ST_SAVE_B;
            ST_SAVE_B: state_d = ST_REDIR;
            ST_REDIR:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Step decode.
    always_comb begin
        capture_o  = (state_q == ST_IDLE) && start_i;
        busy_o     = (state_q != ST_IDLE);
        psr_step_o = (state_q == ST_PSR);
        save_a_o   = (state_q == ST_SAVE_A);
        save_b_o   = (state_q == ST_SAVE_B);
        redir_o    = (state_q == ST_REDIR);
        done_o     = (state_q == ST_DONE);
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Module: register-window trap entry sequencer (top).
// Captures the core state on an accepted start, then drives the status
// update, two register-file saves and the PC redirect over four cycles,
// followed by a done pulse. Assumes the trap was already selected and
// error mode is not set; cwp_i is below NWINDOWS.
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int NWINDOWS = 8,
    parameter int CWP_W    = 5,
    parameter int AW       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic             s_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    npc_i,
    input  logic [AW-1:0]    tbr_i,
    input  logic             annul_i,
    input  logic             rtrap_i,
    output logic             busy_o,
    output logic             psr_we_o,
    output logic [CWP_W-1:0] cwp_o,
    output logic             s_o,
    output logic             ps_o,
    output logic             et_o,
    output logic             rfa_we_o,
    output logic [4:0]       rfa_idx_o,
    output logic [CWP_W-1:0] rfa_win_o,
    output logic [AW-1:0]    rfa_data_o,
    output logic             rfb_we_o,
    output logic [4:0]       rfb_idx_o,
    output logic [CWP_W-1:0] rfb_win_o,
    output logic [AW-1:0]    rfb_data_o,
    output logic             pc_we_o,
    output logic [AW-1:0]    pc_o,
    output logic [AW-1:0]    npc_o,
    output logic             annul_clr_o,
    output logic             rtrap_clr_o,
    output logic             done_o
);
    logic             capture, psr_step, save_a, save_b, redir;
    logic [CWP_W-1:0] cwp_q, cwp_new;
    logic             s_q, annul_q, rtrap_q;
    logic [AW-1:0]    pc_q, npc_q, tbr_q;
    logic [AW-1:0]    ret_a, ret_b, vec_pc, vec_npc;

    twe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .capture_o  (capture),
        .busy_o     (busy_o),
        .psr_step_o (psr_step),
        .save_a_o   (save_a),
        .save_b_o   (save_b),
        .redir_o    (redir),
        .done_o     (done_o)
    );

    // Snapshot of the core state taken on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q   <= '0;
            s_q     <= 1'b0;
            pc_q    <= '0;
            npc_q   <= '0;
            tbr_q   <= '0;
            annul_q <= 1'b0;
            rtrap_q <= 1'b0;
        end else if (capture) begin
            cwp_q   <= cwp_i;
            s_q     <= s_i;
            pc_q    <= pc_i;
            npc_q   <= npc_i;
            tbr_q   <= tbr_i;
            annul_q <= annul_i;
            rtrap_q <= rtrap_i;
        end
    end

    twe_cwp_rot #(.NWIN(NWINDOWS), .CWP_W(CWP_W)) u_rot (
        .cwp_i (cwp_q),
        .cwp_o (cwp_new)
    );

    twe_ret_sel #(.AW(AW)) u_ret (
        .annul_i  (annul_q),
        .pc_i     (pc_q),
        .npc_i    (npc_q),
        .save_a_o (ret_a),
        .save_b_o (ret_b)
    );

    twe_vector_sel #(.AW(AW)) u_vec (
        .rtrap_i (rtrap_q),
        .tbr_i   (tbr_q),
        .pc_o    (vec_pc),
        .npc_o   (vec_npc)
    );

    // Status field outputs: S rises only in the redirect step.
    always_comb begin
        psr_we_o = psr_step | redir;
        cwp_o    = cwp_new;
        et_o     = 1'b0;
        ps_o     = s_q;
        s_o      = redir ? 1'b1 : s_q;
    end

    // Register-file save ports.
    always_comb begin
        rfa_we_o   = save_a;
        rfa_idx_o  = SAVE_IDX_A;
        rfa_win_o  = cwp_new;
        rfa_data_o = ret_a;
        rfb_we_o   = save_b;
        rfb_idx_o  = SAVE_IDX_B;
        rfb_win_o  = cwp_new;
        rfb_data_o = ret_b;
    end

    // Redirect and flag-clear pulses.
    always_comb begin
        pc_we_o     = redir;
        pc_o        = vec_pc;
        npc_o       = vec_npc;
        annul_clr_o = save_b & annul_q;
        rtrap_clr_o = redir & rtrap_q;
    end
endmodule

// File: rtl/trap_entry_chk.sv
// Module: protocol checker for trap_entry_seq, attached by bind.
// Assumes the bound instance uses the same parameter values.
module trap_entry_chk #(
    parameter int NWINDOWS = 8,
    parameter int CWP_W    = 5,
    parameter int AW       = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psr_we_o,
    input logic [CWP_W-1:0] cwp_o,
    input logic             s_o,
    input logic             et_o,
    input logic             rfa_we_o,
    input logic [CWP_W-1:0] rfa_win_o,
    input logic             rfb_we_o,
    input logic [CWP_W-1:0] rfb_win_o,
    input logic             pc_we_o,
    input logic [AW-1:0]    pc_o,
    input logic [AW-1:0]    npc_o,
    input logic             annul_clr_o,
    input logic             rtrap_clr_o,
    input logic             done_o
);
    AST_PSR_THEN_SAVE_A: assert property (@(posedge clk) disable iff (!rst_n) (psr_we_o && !pc_we_o) |=> rfa_we_o); // R2
    AST_SAVE_A_THEN_B: assert property (@(posedge clk) disable iff (!rst_n) rfa_we_o |=> rfb_we_o); // R2
    AST_SAVE_B_THEN_REDIR: assert property (@(posedge clk) disable iff (!rst_n) rfb_we_o |=> pc_we_o); // R2
    AST_REDIR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) pc_we_o |=> done_o); // R2
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rfa_we_o, rfb_we_o, pc_we_o, done_o})); // R2
    AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) psr_we_o |-> (int'(cwp_o) < NWINDOWS)); // R3
    AST_SAVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rfb_we_o |-> (rfb_win_o == $past(rfa_win_o))); // R3
    AST_ET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) psr_we_o |-> !et_o); // R4
    AST_ANNUL_CLR_SLOT: assert property (@(posedge clk) disable iff (!rst_n) annul_clr_o |-> rfb_we_o); // R6
    AST_SUPERVISOR_ON_REDIR: assert property (@(posedge clk) disable iff (!rst_n) pc_we_o |-> s_o); // R7
    AST_NPC_FOLLOWS_PC: assert property (@(posedge clk) disable iff (!rst_n) pc_we_o |-> (npc_o == pc_o + AW'(4))); // R7
    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) rtrap_clr_o |-> (pc_we_o && pc_o == '0)); // R8
endmodule

bind trap_entry_seq trap_entry_chk #(.NWINDOWS(NWINDOWS), .CWP_W(CWP_W), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .psr_we_o    (psr_we_o),
    .cwp_o       (cwp_o),
    .s_o         (s_o),
    .et_o        (et_o),
    .rfa_we_o    (rfa_we_o),
    .rfa_win_o   (rfa_win_o),
    .rfb_we_o    (rfb_we_o),
    .rfb_win_o   (rfb_win_o),
    .pc_we_o     (pc_we_o),
    .pc_o        (pc_o),
    .npc_o       (npc_o),
    .annul_clr_o (annul_clr_o),
    .rtrap_clr_o (rtrap_clr_o),
    .done_o      (done_o)
);

// File: tb/trap_entry_seq_tb_top.sv
// Scoreboard bench: the driver pushes expected step items, the monitor pops
// and compares one item per active output cycle at the falling edge.
module trap_entry_seq_tb_top;
    localparam int NW = 8;
    localparam int CW = 5;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [CW-1:0] cwp_i = '0;
    logic s_i = 1'b0;
    logic [AW-1:0] pc_i = '0, npc_i = '0, tbr_i = '0;
    logic annul_i = 1'b0, rtrap_i = 1'b0;
    logic busy_o, psr_we_o, s_o, ps_o, et_o, rfa_we_o, rfb_we_o, pc_we_o;
    logic annul_clr_o, rtrap_clr_o, done_o;
    logic [CW-1:0] cwp_o, rfa_win_o, rfb_win_o;
    logic [4:0] rfa_idx_o, rfb_idx_o;
    logic [AW-1:0] rfa_data_o, rfb_data_o, pc_o, npc_o;

    int n_tests = 0;
    int n_fail = 0;

    // 125 MHz: 8 ns period.
    always #4 clk = ~clk;

    trap_entry_seq #(.NWINDOWS(NW), .CWP_W(CW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cwp_i(cwp_i), .s_i(s_i),
        .pc_i(pc_i), .npc_i(npc_i), .tbr_i(tbr_i), .annul_i(annul_i), .rtrap_i(rtrap_i),
        .busy_o(busy_o), .psr_we_o(psr_we_o), .cwp_o(cwp_o), .s_o(s_o), .ps_o(ps_o),
        .et_o(et_o), .rfa_we_o(rfa_we_o), .rfa_idx_o(rfa_idx_o), .rfa_win_o(rfa_win_o),
        .rfa_data_o(rfa_data_o), .rfb_we_o(rfb_we_o), .rfb_idx_o(rfb_idx_o),
        .rfb_win_o(rfb_win_o), .rfb_data_o(rfb_data_o), .pc_we_o(pc_we_o), .pc_o(pc_o),
        .npc_o(npc_o), .annul_clr_o(annul_clr_o), .rtrap_clr_o(rtrap_clr_o), .done_o(done_o)
    );

    // Kinds: 0 status write, 1 port A, 2 port B, 3 redirect, 4 done.
    typedef struct packed {
        logic [2:0]    kind;
        logic [AW-1:0] v0, v1, v2, v3;
    } item_t;

    item_t exp_q[$];

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd0: tag_of = "R3/R4 status";
            3'd1: tag_of = "R5/R6 port A";
            3'd2: tag_of = "R5/R6 port B";
            3'd3: tag_of = "R7/R8 redirect";
            default: tag_of = "R2 done";
        endcase
    endfunction

    // Driver: compute expectations from the requirements, then pulse start.
    task automatic run_trap(input logic [CW-1:0] cwp, input logic s, input logic [AW-1:0] pc,
                            input logic [AW-1:0] npc, input logic [AW-1:0] tbr,
                            input logic an, input logic rt, input logic poke_busy);
        logic [CW-1:0] w;
        item_t it;
        w = (cwp == 0) ? CW'(NW - 1) : cwp - 1'b1;                        // R3
        it = '{kind: 3'd0, v0: AW'(w), v1: AW'({s, s, 1'b0}), v2: '0, v3: '0}; // R4
        exp_q.push_back(it);
        it = '{kind: 3'd1, v0: AW'(17), v1: AW'(w), v2: an ? npc : pc, v3: '0};  // R5 R6
        exp_q.push_back(it);
        it = '{kind: 3'd2, v0: AW'(18), v1: AW'(w), v2: an ? npc + 4 : npc, v3: AW'(an)}; // R6
        exp_q.push_back(it);
        it = '{kind: 3'd3, v0: rt ? '0 : tbr, v1: rt ? AW'(4) : tbr + 4,
               v2: AW'({1'b1, s, 1'b0, w}), v3: AW'(rt)};                     // R7 R8
        exp_q.push_back(it);
        it = '{kind: 3'd4, v0: AW'(1), v1: '0, v2: '0, v3: '0};
        exp_q.push_back(it);
        @(negedge clk);
        cwp_i = cwp; s_i = s; pc_i = pc; npc_i = npc; tbr_i = tbr; annul_i = an; rtrap_i = rt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            // R9: a second start mid-sequence with other values must be ignored.
            @(negedge clk);
            cwp_i = ~cwp; s_i = ~s; pc_i = ~pc; npc_i = ~npc; tbr_i = ~tbr;
            annul_i = ~an; rtrap_i = ~rt; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (5) @(negedge clk);
        end else begin
            repeat (6) @(negedge clk);
        end
    endtask

    // Monitor: pop and compare one item per active output cycle.
    always @(negedge clk) begin
        if (rst_n && (psr_we_o || rfa_we_o || rfb_we_o || pc_we_o || done_o)) begin
            item_t got, exp;
            if (pc_we_o)
                got = '{kind: 3'd3, v0: pc_o, v1: npc_o, v2: AW'({s_o, ps_o, et_o, cwp_o}), v3: AW'(rtrap_clr_o)};
            else if (rfb_we_o)
                got = '{kind: 3'd2, v0: AW'(rfb_idx_o), v1: AW'(rfb_win_o), v2: rfb_data_o, v3: AW'(annul_clr_o)};
            else if (rfa_we_o)
                got = '{kind: 3'd1, v0: AW'(rfa_idx_o), v1: AW'(rfa_win_o), v2: rfa_data_o, v3: AW'(annul_clr_o)};
            else if (psr_we_o)
                got = '{kind: 3'd0, v0: AW'(cwp_o), v1: AW'({ps_o, s_o, et_o}), v2: '0, v3: AW'(rtrap_clr_o)};
            else
                got = '{kind: 3'd4, v0: AW'(busy_o), v1: '0, v2: '0, v3: AW'(annul_clr_o | rtrap_clr_o)};
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2/R9 unexpected item: actual kind=%0d v0=%h, expected none", got.kind, got.v0);
            end else begin
                exp = exp_q.pop_front();
                if (got != exp) begin
                    n_fail++;
                    $display("FAIL %s: actual k=%0d %h %h %h %h, expected k=%0d %h %h %h %h",
                             tag_of(exp.kind), got.kind, got.v0, got.v1, got.v2, got.v3,
                             exp.kind, exp.v0, exp.v1, exp.v2, exp.v3);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        n_tests++;
        if ({busy_o, done_o, psr_we_o, rfa_we_o, rfb_we_o, pc_we_o, annul_clr_o, rtrap_clr_o} != 8'd0) begin
            n_fail++;
            $display("FAIL R1 reset: actual busy=%b done=%b strobes=%b, expected 0",
                     busy_o, done_o, {psr_we_o, rfa_we_o, rfb_we_o, pc_we_o, annul_clr_o, rtrap_clr_o});
        end
        run_trap(5'd3, 1'b0, 32'h0000_1000, 32'h0000_1004, 32'h4000_0800, 1'b0, 1'b0, 1'b0); // R5 R7
        run_trap(5'd0, 1'b1, 32'h0000_2040, 32'h0000_2044, 32'h4000_0900, 1'b1, 1'b0, 1'b0); // R3 wrap, R6
        run_trap(5'd7, 1'b1, 32'h0000_3000, 32'h0000_3100, 32'h4000_0a00, 1'b0, 1'b1, 1'b0); // R8
        run_trap(5'd1, 1'b0, 32'hffff_fff8, 32'hffff_fffc, 32'hffff_fffc, 1'b1, 1'b1, 1'b0); // R6 R8 overflow
        run_trap(5'd0, 1'b0, 32'h0000_5000, 32'h0000_5004, 32'h4000_0b00, 1'b0, 1'b0, 1'b1); // R9
        run_trap(5'd4, 1'b1, 32'h0000_6000, 32'h0000_6008, 32'h4000_0c00, 1'b1, 1'b0, 1'b0); // R2 back to back
        repeat (3) @(negedge clk);
        // R2: every expected item was produced.
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing items: actual %0d left, expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule